// File: doc/BRIEF.md
# Configurable GPIO Port Controller

This block manages one 16-bit general-purpose I/O port. Four software registers set up the port: a data latch, a direction mask, an attribute mask and a special-function mask. Software reaches them over a simple word-wide bus with a write strobe and a read strobe. Each pin is either an input or an output. The attribute bit changes its meaning with the direction. On an input it selects whether the pin floats or has a pull resistor. On an output it selects whether the data bit is driven inverted or as written.

The block drives the pad models through registered signals: drive level, drive enable, pull enable and pull direction. A pin whose special-function bit is set is handed to a peripheral, which then supplies the drive level and drive enable for that pin. Software can read the data latch and also the real level on the pins. The pin level is brought into the clock domain through a two-flop synchronizer before it reaches the read path.

Top module: `gpio_port_ctrl`

## Requirements
- R1: Bus addresses 0 (data), 1 (direction), 2 (attribute) and 3 (special-function) are written by `bus_wr_en` and read back on `bus_rdata` one clock after `bus_rd_en`. Address 4 is read-only: it returns the synchronized pin level, and a write to it changes no register. `bus_rdata` keeps its last value when no read is issued.
- R2: A direction bit of 1 drives the pin (`pad_oe`=1) and a direction bit of 0 leaves it undriven. `pad_out` is 0 on every undriven pin. Pad outputs reflect a register write two clocks after the write strobe.
- R3: On an input pin with attribute 0, `pad_pull_en` is 1 and `pad_pull_up` equals the data bit (1 selects pull-up, 0 selects pull-down).
- R4: On an input pin with attribute 1, the pin floats: `pad_pull_en` and `pad_pull_up` are both 0.
- R5: On an output pin with attribute 0, `pad_out` is the inverse of the data bit, so writing 1 drives 0.
- R6: On an output pin with attribute 1, `pad_out` equals the data bit.
- R7: The level on `pad_in` is seen on an address-4 read only after it has passed two synchronizer flops. A read issued in the cycle after a change still returns the old level, and a read issued two cycles later returns the new one.
- R8: On a pin whose special-function bit is 1, `periph_oe` and `periph_out` replace the direction and data bits. The peripheral level is driven without inversion, and pads follow a peripheral change one clock later. When the peripheral does not drive the pin, the attribute bit still selects pull or float, and the data bit still selects the pull direction.
- R9: A synchronous active-high reset clears all four registers and `bus_rdata`. Every pin starts as an undriven input with a pull-down enabled (`pad_pull_en` all ones, `pad_pull_up`, `pad_oe` and `pad_out` all zeros).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| pad_in | input | 16 | Level on the pins, asynchronous |
| periph_out | input | 16 | Peripheral drive level per pin |
| periph_oe | input | 16 | Peripheral drive enable per pin |
| pad_out | output | 16 | Level driven onto the pins |
| pad_oe | output | 16 | Drive enable per pin |
| pad_pull_en | output | 16 | Pull resistor enable per pin |
| pad_pull_up | output | 16 | Pull direction, 1 = up |

## Verification
The hardest case to reach from the ports is a pin held by a peripheral while the peripheral releases it. Here the pull logic must fall back to the GPIO attribute and data bits, even though the direction bit for the pin may say output. The bench sets up a port with mixed direction and attribute masks, hands a nibble to the peripheral, and toggles the peripheral drive enable on it. The bench also runs a long random phase: it changes the registers, the peripheral inputs and the pin levels in the same cycles, and its cycle-level model is compared on every clock.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic [2:0] {
    ADDR_DATA = 3'd0,
    ADDR_DIR  = 3'd1,
    ADDR_ATTR = 3'd2,
    ADDR_SPEC = 3'd3,
    ADDR_PIN  = 3'd4
  } gpio_addr_e;
endpackage

// File: rtl/gpio_regfile.sv
module gpio_regfile #(
  parameter int WIDTH = 16,
  parameter int AW    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [WIDTH-1:0] pin_level,
  output logic [WIDTH-1:0] data_q,
  output logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] attr_q,
  output logic [WIDTH-1:0] spec_q,
  output logic [WIDTH-1:0] rdata
);
  import gpio_port_pkg::*;

  logic [WIDTH-1:0] rd_mux;

  // register writes
  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      dir_q  <= '0;
      attr_q <= '0;
      spec_q <= '0;
    end else if (wr_en) begin
      case (addr)
        ADDR_DATA: data_q <= wdata;
        ADDR_DIR:  dir_q  <= wdata;
        ADDR_ATTR: attr_q <= wdata;
        ADDR_SPEC: spec_q <= wdata;
        default:   ;
      endcase
    end
  end

  // read selection
  always_comb begin
    case (addr)
      ADDR_DATA: rd_mux = data_q;
      ADDR_DIR:  rd_mux = dir_q;
      ADDR_ATTR: rd_mux = attr_q;
      ADDR_SPEC: rd_mux = spec_q;
      ADDR_PIN:  rd_mux = pin_level;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= din;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/gpio_pin_logic.sv
module gpio_pin_logic #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] data_q,
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] attr_q,
  input  logic [WIDTH-1:0] spec_q,
  input  logic [WIDTH-1:0] periph_out,
  input  logic [WIDTH-1:0] periph_oe,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_pull_en,
  output logic [WIDTH-1:0] pad_pull_up
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_pin
    logic drive;
    logic level;
    logic pull;

    always_comb begin
      if (spec_q[g]) begin
        drive = periph_oe[g];
        level = periph_out[g];
      end else begin
        drive = dir_q[g];
        level = attr_q[g] ? data_q[g] : ~data_q[g];
      end
      pull = ~drive & ~attr_q[g];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        pad_oe[g]      <= 1'b0;
        pad_out[g]     <= 1'b0;
        pad_pull_en[g] <= 1'b1;
        pad_pull_up[g] <= 1'b0;
      end else begin
        pad_oe[g]      <= drive;
        pad_out[g]     <= drive & level;
        pad_pull_en[g] <= pull;
        pad_pull_up[g] <= pull & data_q[g];
      end
    end
  end
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl #(
  parameter int WIDTH       = 16,
  parameter int AW          = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr_en,
  input  logic             bus_rd_en,
  input  logic [AW-1:0]    bus_addr,
  input  logic [WIDTH-1:0] bus_wdata,
  output logic [WIDTH-1:0] bus_rdata,
  input  logic [WIDTH-1:0] pad_in,
  input  logic [WIDTH-1:0] periph_out,
  input  logic [WIDTH-1:0] periph_oe,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_pull_en,
  output logic [WIDTH-1:0] pad_pull_up
);
  logic [WIDTH-1:0] data_q, dir_q, attr_q, spec_q, pin_level;

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(pad_in), .dout(pin_level)
  );

  gpio_regfile #(.WIDTH(WIDTH), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(bus_wr_en), .rd_en(bus_rd_en),
    .addr(bus_addr), .wdata(bus_wdata), .pin_level(pin_level),
    .data_q(data_q), .dir_q(dir_q), .attr_q(attr_q), .spec_q(spec_q),
    .rdata(bus_rdata)
  );

  gpio_pin_logic #(.WIDTH(WIDTH)) u_pins (
    .clk(clk), .rst(rst),
    .data_q(data_q), .dir_q(dir_q), .attr_q(attr_q), .spec_q(spec_q),
    .periph_out(periph_out), .periph_oe(periph_oe),
    .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_pull_en(pad_pull_en), .pad_pull_up(pad_pull_up)
  );
endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] data_q,
  input logic [WIDTH-1:0] dir_q,
  input logic [WIDTH-1:0] attr_q,
  input logic [WIDTH-1:0] spec_q,
  input logic [WIDTH-1:0] bus_rdata,
  input logic [WIDTH-1:0] pad_out,
  input logic [WIDTH-1:0] pad_oe,
  input logic [WIDTH-1:0] pad_pull_en,
  input logic [WIDTH-1:0] pad_pull_up
);
  AST_UNDRIVEN_LOW: assert property (@(posedge clk) disable iff (rst)
    (pad_out & ~pad_oe) == '0); // R2

  AST_NO_PULL_WHEN_DRIVEN: assert property (@(posedge clk) disable iff (rst)
    (pad_pull_en & pad_oe) == '0); // R3

  AST_PULLUP_NEEDS_PULL: assert property (@(posedge clk) disable iff (rst)
    (pad_pull_up & ~pad_pull_en) == '0); // R3

  AST_FLOAT_ON_ATTR: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (pad_pull_en & $past(attr_q)) == '0); // R4

  AST_OUT_INVERTED: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pad_out ^ ~$past(data_q)) & $past(dir_q & ~attr_q & ~spec_q)) == '0); // R5

  AST_OUT_PLAIN: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pad_out ^ $past(data_q)) & $past(dir_q & attr_q & ~spec_q)) == '0); // R6

  AST_RESET_CLEAN: assert property (@(posedge clk)
    $past(rst) |-> (bus_rdata == '0 && pad_oe == '0 && pad_pull_up == '0)); // R9
endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst),
  .data_q(data_q), .dir_q(dir_q), .attr_q(attr_q), .spec_q(spec_q),
  .bus_rdata(bus_rdata), .pad_out(pad_out), .pad_oe(pad_oe),
  .pad_pull_en(pad_pull_en), .pad_pull_up(pad_pull_up)
);

// File: tb/gpio_port_ctrl_test.sv
`timescale 1ns/1ps
module gpio_port_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr_en = 1'b0, bus_rd_en = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0, pad_in = '0, periph_out = '0, periph_oe = '0;
  logic [15:0] bus_rdata, pad_out, pad_oe, pad_pull_en, pad_pull_up;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_port_ctrl uut (
    .clk(clk), .rst(rst), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .periph_out(periph_out), .periph_oe(periph_oe),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pull_en(pad_pull_en),
    .pad_pull_up(pad_pull_up)
  );

  // behavioural reference state
  logic [15:0] m_reg [4];
  logic [15:0] m_s1, m_s2, m_rd, m_out, m_oe, m_pen, m_pup;

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    logic [15:0] n_rd, n_out, n_oe, n_pen, n_pup;
    logic [15:0] n_reg [4];
    if (rst) begin
      for (int i = 0; i < 4; i++) m_reg[i] = '0;
      m_s1 = '0; m_s2 = '0; m_rd = '0;
      m_out = '0; m_oe = '0; m_pen = '1; m_pup = '0;
    end else begin
      for (int i = 0; i < 4; i++) n_reg[i] = m_reg[i];
      if (bus_wr_en && bus_addr < 3'd4) n_reg[bus_addr[1:0]] = bus_wdata;
      n_rd = m_rd;
      if (bus_rd_en) n_rd = (bus_addr < 3'd4) ? m_reg[bus_addr[1:0]] :
                            (bus_addr == 3'd4) ? m_s2 : 16'h0;
      for (int b = 0; b < 16; b++) begin
        bit drv, lvl;
        if (m_reg[3][b]) begin drv = periph_oe[b]; lvl = periph_out[b]; end
        else begin drv = m_reg[1][b]; lvl = m_reg[2][b] ? m_reg[0][b] : !m_reg[0][b]; end
        n_oe[b]  = drv;
        n_out[b] = drv && lvl;
        n_pen[b] = !drv && !m_reg[2][b];
        n_pup[b] = n_pen[b] && m_reg[0][b];
      end
      m_s2 = m_s1; m_s1 = pad_in; m_rd = n_rd;
      m_out = n_out; m_oe = n_oe; m_pen = n_pen; m_pup = n_pup;
      for (int i = 0; i < 4; i++) m_reg[i] = n_reg[i];
    end
  end

  // compare against model on every clock
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(bus_rdata, m_rd, "R1 model rdata");
      chk(pad_oe, m_oe, "R2 model pad_oe");
      chk(pad_out, m_out, "R5 model pad_out");
      chk(pad_pull_en, m_pen, "R3 model pull_en");
      chk(pad_pull_up, m_pup, "R4 model pull_up");
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_rd_en = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd_en = 1'b0;
    d = bus_rdata;
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk(pad_oe, 16'h0000, "R9 reset pad_oe");
    chk(pad_pull_en, 16'hFFFF, "R9 reset pull_en");
    chk(pad_pull_up, 16'h0000, "R9 reset pull_up");
    chk(bus_rdata, 16'h0000, "R9 reset rdata");
    // R3 pull direction from data
    wr(3'd0, 16'hA5A5);
    @(negedge clk);
    chk(pad_pull_up, 16'hA5A5, "R3 pull direction");
    // R4 float on attribute
    wr(3'd2, 16'h00FF);
    @(negedge clk);
    chk(pad_pull_en, 16'hFF00, "R4 float pull_en");
    chk(pad_pull_up, 16'hA500, "R4 float pull_up");
    // R2 timing: pads change two clocks after strobe
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = 3'd1; bus_wdata = 16'hFFFF;
    @(negedge clk);
    bus_wr_en = 1'b0;
    chk(pad_oe, 16'h0000, "R2 oe not yet");
    @(negedge clk);
    chk(pad_oe, 16'hFFFF, "R2 oe after two clocks");
    // R5 and R6
    chk(pad_out & 16'hFF00, 16'h5A00, "R5 inverted byte");
    chk(pad_out & 16'h00FF, 16'h00A5, "R6 plain byte");
    // R1 readback and read-only address 4
    wr(3'd4, 16'h1111);
    rd(3'd0, v); chk(v, 16'hA5A5, "R1 data readback");
    rd(3'd1, v); chk(v, 16'hFFFF, "R1 dir readback");
    rd(3'd2, v); chk(v, 16'h00FF, "R1 attr readback");
    rd(3'd3, v); chk(v, 16'h0000, "R1 spec readback");
    // R7 synchronizer delay
    @(negedge clk); pad_in = 16'h1234;
    rd(3'd4, v); chk(v, 16'h0000, "R7 old level");
    rd(3'd4, v); chk(v, 16'h1234, "R7 new level");
    // R8 special function
    periph_out = 16'h0003; periph_oe = 16'h0005;
    wr(3'd3, 16'h000F);
    @(negedge clk);
    chk(pad_oe & 16'h000F, 16'h0005, "R8 periph oe");
    chk(pad_out & 16'h000F, 16'h0001, "R8 periph out");
    wr(3'd2, 16'h00F0);
    @(negedge clk);
    chk(pad_pull_en & 16'h000F, 16'h000A, "R8 released pins pull");
    chk(pad_pull_up & 16'h000F, 16'h0000, "R8 pull direction from data");
    periph_oe = 16'h000F;
    @(negedge clk);
    chk(pad_oe & 16'h000F, 16'h000F, "R8 one clock latency");
    // random phase compared by model
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      bus_wr_en  = ($urandom_range(0, 3) == 0);
      bus_rd_en  = ($urandom_range(0, 2) == 0);
      bus_addr   = 3'($urandom_range(0, 5));
      bus_wdata  = 16'($urandom);
      pad_in     = 16'($urandom);
      periph_out = 16'($urandom);
      periph_oe  = 16'($urandom);
    end
    @(negedge clk);
    bus_wr_en = 1'b0; bus_rd_en = 1'b0;
    // R9 reset mid-run
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(pad_oe, 16'h0000, "R9 re-reset oe");
    chk(pad_pull_en, 16'hFFFF, "R9 re-reset pull_en");
    rd(3'd1, v); chk(v, 16'h0000, "R9 re-reset dir");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule